// File: doc/BRIEF.md
# Hysteretic Input Level Detector with Dwell Timer

This block watches a stream of ADC samples, one per clock, and drives a complementary level-indicator pair that an external attenuator or gain stage uses for gain control. The most significant ten bits of each sample are compared with two programmable thresholds. The indicator goes active as soon as a sample reaches the upper threshold. It goes inactive only after the signal has stayed at or below the lower threshold for a programmable number of consecutive clocks. Any sample above the lower threshold during that wait restarts the wait.

A small write port loads four registers: the lower threshold, the upper threshold, the dwell count, and a control word. The control word holds the output polarity and a delay of 0 to 7 clocks. The delay lets the indicator line up with the latency of the converter and with the settling of the external gain stage.

Top module: `level_detect_top`

## Requirements
- R1: After synchronous reset, ind_out is 0 and ind_out_n is 1. All four registers read as zero, so the detector is disabled (see R6).
- R2: A write with wr_en high loads wr_data into the register that wr_addr selects: 0 = lower threshold (bits 9:0), 1 = upper threshold (bits 9:0), 2 = dwell count (bits 19:0), 3 = control. The new value is used from the next clock on.
- R3: The detector is active when the dwell count is non-zero. While it is inactive, a sample whose top 10 bits are greater than or equal to the upper threshold makes the indicator state active at that clock edge. An upper threshold of exactly the sample value counts as met.
- R4: While the indicator is active, a sample whose top 10 bits are above the lower threshold, or at or above the upper threshold, restarts the dwell wait. The indicator stays active.
- R5: While the indicator is active, it becomes inactive on the clock of the D-th consecutive sample whose top 10 bits are less than or equal to the lower threshold and below the upper threshold. D is the dwell count. A sample equal to the lower threshold counts as low, and with D = 1 a single low sample releases the indicator.
- R6: A dwell count of 0 disables detection: the indicator state is forced inactive on the next clock and stays inactive whatever the samples are.
- R7: Control bit 4 selects polarity. When it is 0, ind_out is 1 while the indicator is active. When it is 1, ind_out is 0 while active and 1 while inactive. A polarity change shows on ind_out one clock after the write takes effect.
- R8: Control bits 2:0 hold a delay d. ind_out follows the indicator state with a latency of 1 + d clocks. A change of d selects from the history already recorded, starting with the next clock. Bit 3 has no effect.
- R9: ind_out_n is always the inverse of ind_out.
- R10: While the indicator is inactive, samples below the upper threshold leave the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 20 | Register write data |
| sample | input | 14 | ADC sample; the top 10 bits are compared |
| ind_out | output | 1 | Level indicator after delay and polarity |
| ind_out_n | output | 1 | Inverse of ind_out |

## Verification
The bench uses hand-built runs that place samples exactly on the upper and lower thresholds. This separates a ">=" compare from a ">" compare, and a "<=" compare from a "<" compare. Low runs of length D-1 followed by a sample between the thresholds show that the wait restarts rather than pauses. A following run of exactly D low samples fixes the release clock. Mid-band samples while the indicator is inactive show the hysteresis. Dwell 1 and dwell 0 cover the boundary and the disabled case. A long pseudo-random phase then switches polarity and delay while samples cross both thresholds. Every clock of that phase is compared with the reference model, which exposes off-by-one errors in the delay tap and polarity applied at the wrong stage.

// File: rtl/ld_pkg.sv
package ld_pkg;
  typedef enum logic [1:0] {
    SEL_LOWER = 2'd0,
    SEL_UPPER = 2'd1,
    SEL_DWELL = 2'd2,
    SEL_CTRL  = 2'd3
  } ld_sel_e;

  localparam int CTRL_POL_BIT = 4;
endpackage

// File: rtl/ld_regs.sv
module ld_regs
  import ld_pkg::*;
#(
  parameter int THR_W   = 10,
  parameter int DWELL_W = 20,
  parameter int DLY_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DWELL_W-1:0] wr_data,
  output logic [THR_W-1:0]   lower_thr,
  output logic [THR_W-1:0]   upper_thr,
  output logic [DWELL_W-1:0] dwell,
  output logic               pol,
  output logic [DLY_W-1:0]   dly
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lower_thr <= '0;
      upper_thr <= '0;
      dwell     <= '0;
      pol       <= 1'b0;
      dly       <= '0;
    end else if (wr_en) begin
      case (ld_sel_e'(wr_addr))
        SEL_LOWER: lower_thr <= wr_data[THR_W-1:0];
        SEL_UPPER: upper_thr <= wr_data[THR_W-1:0];
        SEL_DWELL: dwell     <= wr_data;
        SEL_CTRL: begin
          pol <= wr_data[CTRL_POL_BIT];
          dly <= wr_data[DLY_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // R2: a write to the lower threshold is visible on the next clock
  assert_wr_lower_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0) |=> (lower_thr == $past(wr_data[THR_W-1:0])));
endmodule

// File: rtl/ld_core.sv
module ld_core #(
  parameter int SAMPLE_W = 14,
  parameter int THR_W    = 10,
  parameter int DWELL_W  = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [THR_W-1:0]    lower_thr,
  input  logic [THR_W-1:0]    upper_thr,
  input  logic [DWELL_W-1:0]  dwell,
  output logic                active
);
  logic [THR_W-1:0]   msb;
  logic               at_upper;
  logic               above_lower;
  logic               enabled;
  logic [DWELL_W-1:0] cnt;

  assign msb         = sample[SAMPLE_W-1 -: THR_W];
  assign at_upper    = (msb >= upper_thr);
  assign above_lower = (msb > lower_thr);
  assign enabled     = (dwell != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!enabled) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (at_upper) begin
        active <= 1'b1;
        cnt    <= dwell;
      end
    end else if (at_upper || above_lower) begin
      cnt <= dwell;
    end else if (cnt <= 1) begin
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R3: reaching the upper threshold while enabled activates the indicator
  assert_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (enabled && at_upper) |=> active);
  // R4: a sample above the lower threshold keeps an active indicator active
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (active && enabled && above_lower) |=> active);
  // R6: a zero dwell count forces the indicator inactive
  assert_disable_R6: assert property (@(posedge clk) disable iff (rst)
    (!enabled) |=> !active);
  // R5: an active indicator always has a pending dwell count
  assert_cnt_live_R5: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt != '0));
endmodule

// File: rtl/ld_outstage.sv
module ld_outstage #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             pol,
  input  logic [DLY_W-1:0] dly,
  output logic             ind_out,
  output logic             ind_out_n
);
  localparam int MAX_DLY = (1 << DLY_W) - 1;

  logic [MAX_DLY:0] hist;
  logic             tap;

  assign hist[0] = active;

  generate
    for (genvar i = 1; i <= MAX_DLY; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) hist[i] <= 1'b0;
        else     hist[i] <= hist[i-1];
      end
    end
  endgenerate

  assign tap = hist[dly];

  always_ff @(posedge clk) begin
    if (rst) begin
      ind_out   <= 1'b0;
      ind_out_n <= 1'b1;
    end else begin
      ind_out   <= tap ^ pol;
      ind_out_n <= ~(tap ^ pol);
    end
  end

  // R9: the output pair is complementary
  assert_pair_R9: assert property (@(posedge clk) disable iff (rst)
    ind_out == !ind_out_n);
endmodule

// File: rtl/level_detect_top.sv
module level_detect_top #(
  parameter int SAMPLE_W = 14,
  parameter int THR_W    = 10,
  parameter int DWELL_W  = 20,
  parameter int DLY_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [DWELL_W-1:0]  wr_data,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                ind_out,
  output logic                ind_out_n
);
  logic [THR_W-1:0]   lower_thr;
  logic [THR_W-1:0]   upper_thr;
  logic [DWELL_W-1:0] dwell;
  logic               pol;
  logic [DLY_W-1:0]   dly;
  logic               active;

  ld_regs #(.THR_W(THR_W), .DWELL_W(DWELL_W), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lower_thr(lower_thr), .upper_thr(upper_thr), .dwell(dwell),
    .pol(pol), .dly(dly)
  );

  ld_core #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W), .DWELL_W(DWELL_W)) u_core (
    .clk(clk), .rst(rst), .sample(sample), .lower_thr(lower_thr),
    .upper_thr(upper_thr), .dwell(dwell), .active(active)
  );

  ld_outstage #(.DLY_W(DLY_W)) u_out (
    .clk(clk), .rst(rst), .active(active), .pol(pol), .dly(dly),
    .ind_out(ind_out), .ind_out_n(ind_out_n)
  );
endmodule

// File: tb/level_detect_top_test.sv
`timescale 1ns/1ps
module level_detect_top_test;
  localparam int SW = 14;
  localparam int TW = 10;
  localparam int DW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [SW-1:0] sample = '0;
  logic          ind_out, ind_out_n;

  level_detect_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sample(sample), .ind_out(ind_out), .ind_out_n(ind_out_n)
  );

  always #2 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 0;
  string req = "R1";

  // reference model state
  int m_lo, m_up, m_dw, m_d, run;
  bit m_pol, m_act, m_out;
  bit q[$];

  always @(posedge clk) begin
    int top;
    bit tap;
    top = int'(sample[SW-1 -: TW]);
    if (rst) begin
      m_lo = 0; m_up = 0; m_dw = 0; m_d = 0; m_pol = 0;
      m_act = 0; run = 0; m_out = 0;
      q.delete();
      for (int i = 0; i < 8; i++) q.push_back(1'b0);
    end else begin
      tap = q[m_d];
      m_out = tap ^ m_pol;
      if (m_dw == 0) begin
        m_act = 0; run = 0;
      end else if (!m_act) begin
        if (top >= m_up) begin m_act = 1; run = 0; end
      end else if (top >= m_up || top > m_lo) begin
        run = 0;
      end else begin
        run++;
        if (run >= m_dw) begin m_act = 0; run = 0; end
      end
      q.push_front(m_act);
      void'(q.pop_back());
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_lo = int'(wr_data[TW-1:0]);
          2'd1: m_up = int'(wr_data[TW-1:0]);
          2'd2: m_dw = int'(wr_data);
          default: begin m_pol = wr_data[4]; m_d = int'(wr_data[2:0]); end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_cmp++;
      if (ind_out !== m_out || ind_out_n !== !m_out) begin
        n_bad++;
        $display("FAIL %s cycle %0d: ind_out=%b ind_out_n=%b expected %b/%b",
                 req, cyc, ind_out, ind_out_n, m_out, !m_out);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put(input int top, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample = {TW'(top), 4'($urandom)};
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, checked directly
    n_cmp++;
    if (ind_out !== 1'b0 || ind_out_n !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 reset: ind_out=%b ind_out_n=%b expected 0/1", ind_out, ind_out_n);
    end
    req = "R6"; put(1023, 6);               // disabled after reset
    req = "R2"; wr(0, 32'hFFC64);           // lower = 100 (upper bits dropped)
    wr(1, 500); wr(2, 5); wr(3, 0);
    req = "R10"; put(300, 6); put(499, 3);  // mid band, inactive
    req = "R3"; put(500, 1);                // exact upper
    req = "R4"; put(50, 4); put(101, 1); put(50, 4); put(700, 1);
    req = "R5"; put(100, 5); put(300, 4);   // exact lower counts as low
    put(600, 2); put(20, 8);
    req = "R5"; wr(2, 1); put(600, 2); put(100, 1); put(200, 4);
    req = "R7"; wr(3, 32'h10); put(600, 3); put(10, 5);
    req = "R8"; wr(3, 3); put(600, 2); put(10, 12);
    wr(3, 7); put(600, 1); put(10, 4);
    wr(3, 32'h0C); put(10, 3);              // bit 3 reserved, delay 4
    wr(3, 1); put(10, 10);
    req = "R6"; wr(2, 3); put(600, 3); wr(2, 0); put(600, 6);
    req = "R9"; wr(2, 4); wr(0, 200); wr(1, 700);
    for (int k = 0; k < 3000; k++) begin
      if (k % 97 == 0) wr(3, int'($urandom_range(0, 31)));
      put(int'($urandom_range(0, 1023)), 1);
      if (k % 53 == 0) put(int'($urandom_range(0, 200)), int'($urandom_range(1, 6)));
    end
    put(0, 12);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule